// File: doc/BRIEF.md
# Five-by-three system bus crossbar with fixed-priority arbitration

The crossbar joins five bus initiators (instruction fetch, data access, debug, DMA and one expansion master) to three targets: program memory, data RAM and a shared peripheral bus. Each initiator's address is decoded to a single target. Each target has its own arbiter, so transactions to different targets proceed in the same cycle. An initiator whose target is free is granted combinationally, in the cycle it asks.

When several initiators address one target, a fixed priority order decides. A 3-bit mode input picks the order. An initiator that wins keeps the target until the target signals ready. The other requesters wait with their ready low. A request to an address that no target decodes completes at once with an error flag and never reaches a target.

Top module: `bus_xbar`

## Requirements
- R1: Address decode: 0x1D000000–0x1D07FFFF selects target 0 (program memory), 0x00000000–0x0001FFFF selects target 1 (RAM), 0x1F800000–0x1F8FFFFF selects target 2 (peripherals); the granted initiator's address, write enable and write data appear on that target's port.
- R2: Requests from different initiators to three different targets are all granted in the same cycle.
- R3: A request to an idle target is granted combinationally, in the cycle it is presented.
- R4: Under mode 1, colliding requests are served in the order debug (port 2), data (port 1), fetch (port 0), DMA (port 3), expansion (port 4), highest first.
- R5: Under mode 0, the order is debug, fetch, data, DMA, expansion.
- R6: Mode values 2 to 7 give the same order as mode 1.
- R7: A granted initiator keeps its target, even against a higher-priority newcomer, until that target asserts ready; waiting initiators see grant and ready low.
- R8: An initiator's ready equals its grant ANDed with its target's ready, and its read data is routed from that target.
- R9: A request to an unmapped address raises the initiator's error and ready in the same cycle, and drives no target request.
- R10: After reset, no target holds a lock, and with no requests every grant and target request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arb_mode_i | input | 3 | Priority order select |
| m_req_i | input | N_INIT | Initiator request |
| m_addr_i | input | N_INIT×AW | Initiator address |
| m_we_i | input | N_INIT | Initiator write enable |
| m_wdata_i | input | N_INIT×DW | Initiator write data |
| m_gnt_o | output | N_INIT | Initiator granted a target |
| m_ready_o | output | N_INIT | Transfer completes this cycle |
| m_err_o | output | N_INIT | Unmapped address |
| m_rdata_o | output | N_INIT×DW | Read data to initiator |
| s_req_o | output | 3 | Target request |
| s_addr_o | output | 3×AW | Target address |
| s_we_o | output | 3 | Target write enable |
| s_wdata_o | output | 3×DW | Target write data |
| s_rdata_i | input | 3×DW | Target read data |
| s_ready_i | input | 3 | Target ready |

## Verification
On every cycle, the assertions check four properties. Each target grants at most one initiator, and only one that is requesting. An idle target with requesters always grants. An owner whose transfer stalls is still the owner in the next cycle. Unmapped requests error out without a grant. Only the directed scenarios can show the priority order under each mode, the routing of address, data and ready between specific ports, and full concurrency across all three targets.

// File: rtl/bus_xbar_pkg.sv
package bus_xbar_pkg;
  localparam int unsigned N_TGT = 3;
  localparam int unsigned TW    = 2;

  localparam int unsigned INI_FETCH = 0;
  localparam int unsigned INI_DATA  = 1;
  localparam int unsigned INI_DEBUG = 2;
  localparam int unsigned INI_DMA   = 3;
  localparam int unsigned INI_EXP   = 4;

  localparam logic [TW-1:0] TGT_PROG = 2'd0;
  localparam logic [TW-1:0] TGT_RAM  = 2'd1;
  localparam logic [TW-1:0] TGT_PERI = 2'd2;

  // rank 0 is highest; mode 0 swaps fetch above data, every other mode is mode 1
  function automatic int unsigned prio_rank(logic [2:0] mode, int unsigned idx);
    case (idx)
      INI_DEBUG: return 0;
      INI_DATA:  return (mode == 3'd0) ? 2 : 1;
      INI_FETCH: return (mode == 3'd0) ? 1 : 2;
      INI_DMA:   return 3;
      INI_EXP:   return 4;
      default:   return idx;
    endcase
  endfunction
endpackage

// File: rtl/xbar_addr_dec.sv
module xbar_addr_dec
  import bus_xbar_pkg::*;
#(
  parameter int unsigned   AW        = 32,
  parameter logic [AW-1:0] PROG_BASE = 32'h1D00_0000,
  parameter logic [AW-1:0] PROG_MASK = 32'h0007_FFFF,
  parameter logic [AW-1:0] RAM_BASE  = 32'h0000_0000,
  parameter logic [AW-1:0] RAM_MASK  = 32'h0001_FFFF,
  parameter logic [AW-1:0] PERI_BASE = 32'h1F80_0000,
  parameter logic [AW-1:0] PERI_MASK = 32'h000F_FFFF
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [TW-1:0] tgt_o
);
  always_comb begin
    hit_o = 1'b1;
    tgt_o = TGT_RAM;
    if ((addr_i & ~PROG_MASK) == PROG_BASE)      tgt_o = TGT_PROG;
    else if ((addr_i & ~RAM_MASK) == RAM_BASE)   tgt_o = TGT_RAM;
    else if ((addr_i & ~PERI_MASK) == PERI_BASE) tgt_o = TGT_PERI;
    else                                         hit_o = 1'b0;
  end
endmodule

// File: rtl/xbar_tgt_arb.sv
module xbar_tgt_arb
  import bus_xbar_pkg::*;
#(
  parameter int unsigned N_INIT = 5,
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  localparam int unsigned IW    = $clog2(N_INIT)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [2:0]                   mode_i,
  input  logic [N_INIT-1:0]            req_i,
  input  logic [N_INIT-1:0][AW-1:0]    addr_i,
  input  logic [N_INIT-1:0]            we_i,
  input  logic [N_INIT-1:0][DW-1:0]    wdata_i,
  input  logic                         t_ready_i,
  output logic [N_INIT-1:0]            gnt_o,
  output logic                         t_req_o,
  output logic [AW-1:0]                t_addr_o,
  output logic                         t_we_o,
  output logic [DW-1:0]                t_wdata_o
);
  logic [N_INIT-1:0] pick;
  logic              found;
  logic              locked_q;
  logic [IW-1:0]     owner_q, gnt_idx;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int unsigned r = 0; r < N_INIT; r++)
      for (int unsigned i = 0; i < N_INIT; i++)
        if (!found && req_i[i] && prio_rank(mode_i, i) == r) begin
          pick[i] = 1'b1;
          found   = 1'b1;
        end
  end

  always_comb begin
    if (locked_q && req_i[owner_q]) begin
      gnt_o = '0;
      gnt_o[owner_q] = 1'b1;
    end else begin
      gnt_o = pick;
    end
  end

  always_comb begin
    gnt_idx   = '0;
    t_addr_o  = '0;
    t_we_o    = 1'b0;
    t_wdata_o = '0;
    for (int unsigned i = 0; i < N_INIT; i++)
      if (gnt_o[i]) begin
        gnt_idx   = IW'(i);
        t_addr_o  = t_addr_o | addr_i[i];
        t_we_o    = t_we_o | we_i[i];
        t_wdata_o = t_wdata_o | wdata_i[i];
      end
  end

  assign t_req_o = |gnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
    end else if (t_req_o && !t_ready_i) begin
      locked_q <= 1'b1;
      owner_q  <= gnt_idx;
    end else begin
      locked_q <= 1'b0;
    end
  end

  a_r7_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && ((gnt_o & ~req_i) == '0));

  a_r3_idle_grants: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_q && |req_i) |-> t_req_o);

  a_r7_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_req_o && !t_ready_i) |=>
      ((gnt_o == $past(gnt_o)) || ((req_i & $past(gnt_o)) == '0)));
endmodule

// File: rtl/bus_xbar.sv
module bus_xbar
  import bus_xbar_pkg::*;
#(
  parameter int unsigned N_INIT = 5,
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [2:0]                   arb_mode_i,
  input  logic [N_INIT-1:0]            m_req_i,
  input  logic [N_INIT-1:0][AW-1:0]    m_addr_i,
  input  logic [N_INIT-1:0]            m_we_i,
  input  logic [N_INIT-1:0][DW-1:0]    m_wdata_i,
  output logic [N_INIT-1:0]            m_gnt_o,
  output logic [N_INIT-1:0]            m_ready_o,
  output logic [N_INIT-1:0]            m_err_o,
  output logic [N_INIT-1:0][DW-1:0]    m_rdata_o,
  output logic [N_TGT-1:0]             s_req_o,
  output logic [N_TGT-1:0][AW-1:0]     s_addr_o,
  output logic [N_TGT-1:0]             s_we_o,
  output logic [N_TGT-1:0][DW-1:0]     s_wdata_o,
  input  logic [N_TGT-1:0][DW-1:0]     s_rdata_i,
  input  logic [N_TGT-1:0]             s_ready_i
);
  logic [N_INIT-1:0]                 hit;
  logic [N_INIT-1:0][TW-1:0]         tgt;
  logic [N_TGT-1:0][N_INIT-1:0]      treq, tgnt;

  for (genvar i = 0; i < N_INIT; i++) begin : g_dec
    xbar_addr_dec #(.AW(AW)) u_dec (
      .addr_i (m_addr_i[i]),
      .hit_o  (hit[i]),
      .tgt_o  (tgt[i])
    );
  end

  always_comb begin
    for (int unsigned t = 0; t < N_TGT; t++)
      for (int unsigned i = 0; i < N_INIT; i++)
        treq[t][i] = m_req_i[i] && hit[i] && (tgt[i] == TW'(t));
  end

  for (genvar t = 0; t < N_TGT; t++) begin : g_arb
    xbar_tgt_arb #(.N_INIT(N_INIT), .AW(AW), .DW(DW)) u_arb (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (arb_mode_i),
      .req_i     (treq[t]),
      .addr_i    (m_addr_i),
      .we_i      (m_we_i),
      .wdata_i   (m_wdata_i),
      .t_ready_i (s_ready_i[t]),
      .gnt_o     (tgnt[t]),
      .t_req_o   (s_req_o[t]),
      .t_addr_o  (s_addr_o[t]),
      .t_we_o    (s_we_o[t]),
      .t_wdata_o (s_wdata_o[t])
    );
  end

  always_comb begin
    for (int unsigned i = 0; i < N_INIT; i++) begin
      m_gnt_o[i] = 1'b0;
      for (int unsigned t = 0; t < N_TGT; t++)
        m_gnt_o[i] = m_gnt_o[i] | tgnt[t][i];
      m_err_o[i]   = m_req_i[i] && !hit[i];
      m_ready_o[i] = (m_gnt_o[i] && s_ready_i[tgt[i]]) || m_err_o[i];
      m_rdata_o[i] = m_gnt_o[i] ? s_rdata_i[tgt[i]] : '0;
    end
  end

  for (genvar i = 0; i < N_INIT; i++) begin : g_chk
    a_r9_unmapped_errors: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m_req_i[i] && !hit[i]) |-> (m_err_o[i] && m_ready_o[i] && !m_gnt_o[i]));
    a_r8_ready_needs_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_ready_o[i] |-> (m_gnt_o[i] || m_err_o[i]));
  end
endmodule

// File: tb/bus_xbar_tb_top.sv
module bus_xbar_tb_top;
  localparam int N = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode;
  logic [N-1:0] req, we;
  logic [N-1:0][31:0] addr, wdata;
  logic [N-1:0] gnt, rdy, err;
  logic [N-1:0][31:0] rdata;
  logic [2:0] sreq, swe, srdy;
  logic [2:0][31:0] saddr, swdata, srdata;
  int n_chk = 0, n_fail = 0;

  localparam logic [31:0] A_PROG = 32'h1D00_0100;
  localparam logic [31:0] A_RAM  = 32'h0000_0040;
  localparam logic [31:0] A_PERI = 32'h1F80_0008;

  bus_xbar dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arb_mode_i(mode),
    .m_req_i(req), .m_addr_i(addr), .m_we_i(we), .m_wdata_i(wdata),
    .m_gnt_o(gnt), .m_ready_o(rdy), .m_err_o(err), .m_rdata_o(rdata),
    .s_req_o(sreq), .s_addr_o(saddr), .s_we_o(swe), .s_wdata_o(swdata),
    .s_rdata_i(srdata), .s_ready_i(srdy)
  );

  always #2 clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req = '0; we = '0; addr = '0; wdata = '0; srdy = 3'b111;
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    check("R10 gnt after reset", 64'(gnt), 64'(0));
    check("R10 sreq after reset", 64'(sreq), 64'(0));
  endtask

  task automatic t_concurrent();
    @(negedge clk);
    mode = 3'd1;
    req = 5'b01011;
    addr[0] = A_PROG; addr[1] = A_RAM; addr[3] = A_PERI;
    we[1] = 1'b1; wdata[1] = 32'hCAFE_0001; wdata[3] = 32'hBEEF_0003;
    srdy = 3'b111; #1;
    check("R2 all three granted", 64'(gnt), 64'(5'b01011));
    check("R3 targets requested", 64'(sreq), 64'(3'b111));
    check("R1 prog addr", 64'(saddr[0]), 64'(A_PROG));
    check("R1 ram addr", 64'(saddr[1]), 64'(A_RAM));
    check("R1 peri addr", 64'(saddr[2]), 64'(A_PERI));
    check("R1 ram we", 64'(swe), 64'(3'b010));
    check("R1 ram wdata", 64'(swdata[1]), 64'(32'hCAFE_0001));
    check("R1 peri wdata", 64'(swdata[2]), 64'(32'hBEEF_0003));
    check("R8 rdata fetch", 64'(rdata[0]), 64'(srdata[0]));
    check("R8 rdata dma", 64'(rdata[3]), 64'(srdata[2]));
    srdy = 3'b011; #1;
    check("R8 ready follows target", 64'(rdy), 64'(5'b00011));
    srdy = 3'b111; #1;
    addr[0] = 32'h1D07_FFFC; addr[1] = 32'h0001_FFFC; addr[3] = 32'h1F8F_FFFC; #1;
    check("R1 top-of-range decode", 64'(sreq), 64'(3'b111));
    idle();
  endtask

  task automatic t_prio_mode1(logic [2:0] m, string tag);
    logic [N-1:0] exp_order [5];
    exp_order = '{5'b00100, 5'b00010, 5'b00001, 5'b01000, 5'b10000};
    @(negedge clk);
    mode = m; srdy = 3'b111;
    for (int i = 0; i < N; i++) addr[i] = A_RAM;
    req = 5'b11111;
    for (int k = 0; k < N; k++) begin
      #1;
      check(tag, 64'(gnt), 64'(exp_order[k]));
      @(negedge clk);
      req = req & ~exp_order[k];
    end
    idle();
  endtask

  task automatic t_mode0();
    @(negedge clk);
    mode = 3'd0; srdy = 3'b111;
    addr[0] = A_RAM; addr[1] = A_RAM; addr[3] = A_RAM; req = 5'b01011; #1;
    check("R5 mode0 fetch over data", 64'(gnt), 64'(5'b00001));
    addr[2] = A_RAM; req = 5'b01111; #1;
    check("R5 mode0 debug first", 64'(gnt), 64'(5'b00100));
    req = 5'b01011; mode = 3'd1; #1;
    check("R4 mode1 data over fetch", 64'(gnt), 64'(5'b00010));
    mode = 3'd7; #1;
    check("R6 mode7 as mode1", 64'(gnt), 64'(5'b00010));
    idle();
  endtask

  task automatic t_hold();
    @(negedge clk);
    mode = 3'd1; srdy = 3'b101;
    addr[3] = A_RAM; req = 5'b01000; #1;
    check("R7 dma granted alone", 64'(gnt), 64'(5'b01000));
    @(negedge clk);
    addr[2] = A_RAM; req = 5'b01100; #1;
    check("R7 dma keeps target", 64'(gnt), 64'(5'b01000));
    check("R7 waiter not ready", 64'(rdy), 64'(0));
    srdy = 3'b111; #1;
    check("R7 owner completes", 64'(rdy), 64'(5'b01000));
    @(negedge clk);
    req = 5'b00100; #1;
    check("R7 waiter granted next", 64'(gnt), 64'(5'b00100));
    idle();
  endtask

  task automatic t_unmapped();
    @(negedge clk);
    mode = 3'd1; srdy = 3'b111;
    addr[4] = 32'h4000_0000; addr[1] = 32'h0002_0000; req = 5'b10010; #1;
    check("R9 err flags", 64'(err), 64'(5'b10010));
    check("R9 ready on err", 64'(rdy), 64'(5'b10010));
    check("R9 no target req", 64'(sreq), 64'(0));
    check("R9 no grant", 64'(gnt), 64'(0));
    idle();
  endtask

  initial begin
    mode = 3'd1; req = '0; we = '0; addr = '0; wdata = '0; srdy = 3'b111;
    srdata[0] = 32'hF000_0000; srdata[1] = 32'hF111_1111; srdata[2] = 32'hF222_2222;
    #10 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_concurrent();
    t_prio_mode1(3'd1, "R4 mode1 order");
    t_prio_mode1(3'd3, "R6 mode3 order");
    t_mode0();
    t_hold();
    t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule